// File: doc/BRIEF.md
# PWM Timer Interrupt Request Unit

This block gathers the event sources of an audio PWM timer into one interrupt line and one DMA request. The timer has a buffered compare-A register and a compare-B register. There are three causes. The first is "buffer empty", raised when the compare-A buffer is copied into compare-A. The second is "A match", raised when the counter equals compare-A. The third is "B match", raised when the counter equals compare-B. Each cause has a sticky flag and its own enable bit. Software reads the flags to find the source and writes 1 to a flag to clear it.

The unit tracks whether the compare-A buffer holds fresh data. A buffer-empty flag cannot be cleared until new data has been written to the buffer, so an early clear is overridden. A soft reset marks the buffer empty but holds back both requests until the run control next goes from 0 to 1. That first rising edge lets the initial sample be fetched by the interrupt handler or by DMA. A-match events are dropped while split mode or 8-bit sample resolution is selected.

Top module: `pwm_irq_unit`

## Requirements
- R1: After hardware reset, every flag and every enable reads 0, and both irqOut and dmaReq are 0.
- R2: A bufLoad pulse sets the buffer-empty flag (register bit 0) on the next clock edge.
- R3: A register write with a 1 in bit 0, 1 or 2 clears that flag. A 0 in those bits leaves the flag unchanged. When a set event and a clearing write coincide, the flag stays 1.
- R4: A write-1 clear of bit 0 has no effect unless bufWrite has been pulsed since the most recent bufLoad or soft reset.
- R5: A softReset pulse sets bit 0 and marks the buffer empty. After it, neither irqOut nor dmaReq is raised by buffer empty until runEn goes from 0 to 1, with runEn taken as 0 during hardware reset.
- R6: cntEqA sets the A-match flag (bit 1) only while both splitMode and pcm8Mode are 0.
- R7: cntEqB sets the B-match flag (bit 2).
- R8: Register bits 4, 5 and 6 are the enables for buffer empty, A match and B match. Every register write loads them. irqOut is the OR of each flag ANDed with its enable, and the buffer-empty term is also gated by run and arming as in R5.
- R9: dmaReq is 1 exactly when bit 0 is 1, runEn is 1, the unit is armed and the buffer has not been written since the last load. It does not depend on the bit 4 enable.
- R10: Register read data carries the flags in bits 0 to 2 and the enables in bits 4 to 6. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset, synchronous |
| cntEqA | input | 1 | Counter equals compare-A strobe |
| cntEqB | input | 1 | Counter equals compare-B strobe |
| bufLoad | input | 1 | Compare-A buffer copied into compare-A |
| bufWrite | input | 1 | Compare-A buffer written |
| runEn | input | 1 | Timer run control |
| softReset | input | 1 | Timer soft reset pulse |
| splitMode | input | 1 | Split counter mode selected |
| pcm8Mode | input | 1 | 8-bit sample resolution selected |
| regWrEn | input | 1 | Write strobe for the flag/enable register |
| regWrData | input | REG_W | Write data |
| regRdData | output | REG_W | Flag/enable register read value |
| irqOut | output | 1 | Merged interrupt request |
| dmaReq | output | 1 | DMA request on buffer empty |

## Verification
The bench builds the unit with its default REG_W of 8. At that width the reserved bits 3 and 7 are on the port, so the check that they read 0 is meaningful, and write data with those bits set can be applied. The three-cause width is fixed by the layout, so the directed and random phases cover every pairing of set and clear per cause. This includes set-versus-clear collisions, clears while the buffer is empty, and soft reset with run held high.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;
  localparam int NUM_CAUSE = 3;
  localparam int FLAG_LSB  = 0;
  localparam int EN_LSB    = 4;
  localparam int CAUSE_BE  = 0;
  localparam int CAUSE_AM  = 1;
  localparam int CAUSE_BM  = 2;

  typedef struct packed {
    logic [NUM_CAUSE-1:0] setFlag;
    logic [NUM_CAUSE-1:0] clrFlag;
    logic                 enWr;
    logic [NUM_CAUSE-1:0] enData;
    logic                 reqGate;
  } ctrlStrobe_t;
endpackage

// File: rtl/pwm_irq_ctrl.sv
module pwm_irq_ctrl
  import pwm_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cntEqA,
  input  logic                 cntEqB,
  input  logic                 bufLoad,
  input  logic                 bufWrite,
  input  logic                 runEn,
  input  logic                 softReset,
  input  logic                 splitMode,
  input  logic                 pcm8Mode,
  input  logic                 regWrEn,
  input  logic [NUM_CAUSE-1:0] wrFlagBits,
  input  logic [NUM_CAUSE-1:0] wrEnBits,
  input  logic                 beFlag,
  output ctrlStrobe_t          strb,
  output logic                 dmaReq
);
  logic bufFull;
  logic armed;
  logic runQ;
  logic runRise;

  assign runRise = runEn & ~runQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      armed   <= 1'b0;
      runQ    <= 1'b0;
    end else begin
      runQ <= runEn;
      if (softReset)     bufFull <= 1'b0;
      else if (bufWrite) bufFull <= 1'b1;
      else if (bufLoad)  bufFull <= 1'b0;
      if (softReset)     armed <= 1'b0;
      else if (runRise)  armed <= 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    strb.setFlag[CAUSE_BE] = softReset | bufLoad;
    strb.setFlag[CAUSE_AM] = cntEqA & ~splitMode & ~pcm8Mode;
    strb.setFlag[CAUSE_BM] = cntEqB;
    strb.clrFlag           = regWrEn ? wrFlagBits : '0;
    strb.clrFlag[CAUSE_BE] = regWrEn & wrFlagBits[CAUSE_BE] & bufFull;
    strb.enWr              = regWrEn;
    strb.enData            = wrEnBits;
    strb.reqGate           = armed & runEn;
  end

  assign dmaReq = beFlag & strb.reqGate & ~bufFull;

  // R5
  soft_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> !dmaReq);

  // R9
  write_drops_dma_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWrite |=> !dmaReq);
endmodule

// File: rtl/pwm_irq_regs.sv
module pwm_irq_regs
  import pwm_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  output logic [NUM_CAUSE-1:0] flags,
  output logic [NUM_CAUSE-1:0] enables,
  output logic [REG_W-1:0]     regRdData,
  output logic                 irqOut
);
  logic [NUM_CAUSE-1:0] gateMask;

  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                 flags[i] <= 1'b0;
      else if (strb.setFlag[i])  flags[i] <= 1'b1;
      else if (strb.clrFlag[i])  flags[i] <= 1'b0;
    end

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.setFlag[i] |=> flags[i]);

    // R3
    no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flags[i]) |-> $past(strb.clrFlag[i]));

    if (i == CAUSE_BE) begin : g_gate_be
      assign gateMask[i] = strb.reqGate;
    end else begin : g_gate_other
      assign gateMask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          enables <= '0;
    else if (strb.enWr) enables <= strb.enData;
  end

  always_comb begin
    regRdData = '0;
    regRdData[FLAG_LSB +: NUM_CAUSE] = flags;
    regRdData[EN_LSB   +: NUM_CAUSE] = enables;
  end

  assign irqOut = |(flags & enables & gateMask);
endmodule

// File: rtl/pwm_irq_unit.sv
module pwm_irq_unit
  import pwm_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEqA,
  input  logic             cntEqB,
  input  logic             bufLoad,
  input  logic             bufWrite,
  input  logic             runEn,
  input  logic             softReset,
  input  logic             splitMode,
  input  logic             pcm8Mode,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irqOut,
  output logic             dmaReq
);
  ctrlStrobe_t          strb;
  logic [NUM_CAUSE-1:0] flags;
  logic [NUM_CAUSE-1:0] enables;
  logic                 unusedWrBits;

  assign unusedWrBits = ^{regWrData[EN_LSB-1], regWrData[REG_W-1:EN_LSB+NUM_CAUSE]};

  pwm_irq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntEqA     (cntEqA),
    .cntEqB     (cntEqB),
    .bufLoad    (bufLoad),
    .bufWrite   (bufWrite),
    .runEn      (runEn),
    .softReset  (softReset),
    .splitMode  (splitMode),
    .pcm8Mode   (pcm8Mode),
    .regWrEn    (regWrEn),
    .wrFlagBits (regWrData[FLAG_LSB +: NUM_CAUSE]),
    .wrEnBits   (regWrData[EN_LSB +: NUM_CAUSE]),
    .beFlag     (flags[CAUSE_BE]),
    .strb       (strb),
    .dmaReq     (dmaReq)
  );

  pwm_irq_regs #(.REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .flags     (flags),
    .enables   (enables),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  // R6
  a_match_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[CAUSE_AM]) |-> $past(cntEqA && !splitMode && !pcm8Mode));

  // R8
  no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[EN_LSB +: NUM_CAUSE] == '0) |-> !irqOut);
endmodule

// File: tb/pwm_irq_unit_test.sv
module pwm_irq_unit_test;
  localparam int REG_W = 8;

  logic clk = 1'b0;
  logic rstN, cntEqA, cntEqB, bufLoad, bufWrite, runEn, softReset;
  logic splitMode, pcm8Mode, regWrEn;
  logic [REG_W-1:0] regWrData, regRdData;
  logic irqOut, dmaReq;

  int vecCount = 0;
  int failCount = 0;
  string curReq = "R1";

  // behavioural reference state
  int mBe, mAm, mBm, mEnBe, mEnAm, mEnBm, mFull, mArmed, mRunQ;

  always #4 clk = ~clk;

  pwm_irq_unit #(.REG_W(REG_W)) uut (
    .clk(clk), .rstN(rstN), .cntEqA(cntEqA), .cntEqB(cntEqB),
    .bufLoad(bufLoad), .bufWrite(bufWrite), .runEn(runEn),
    .softReset(softReset), .splitMode(splitMode), .pcm8Mode(pcm8Mode),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .dmaReq(dmaReq)
  );

  function automatic logic [REG_W-1:0] expRd();
    logic [REG_W-1:0] v = '0;
    v[0] = mBe[0]; v[1] = mAm[0]; v[2] = mBm[0];
    v[4] = mEnBe[0]; v[5] = mEnAm[0]; v[6] = mEnBm[0];
    return v;
  endfunction

  function automatic logic expIrq();
    return ((mBe != 0) && (mEnBe != 0) && runEn && (mArmed != 0)) ||
           ((mAm != 0) && (mEnAm != 0)) || ((mBm != 0) && (mEnBm != 0));
  endfunction

  function automatic logic expDma();
    return (mBe != 0) && runEn && (mArmed != 0) && (mFull == 0);
  endfunction

  task automatic modelStep();
    int nBe, nAm, nBm, nFull, nArmed;
    if (!rstN) begin
      mBe = 0; mAm = 0; mBm = 0; mEnBe = 0; mEnAm = 0; mEnBm = 0;
      mFull = 0; mArmed = 0; mRunQ = 0;
      return;
    end
    nBe = mBe; nAm = mAm; nBm = mBm; nFull = mFull; nArmed = mArmed;
    if (softReset || bufLoad) nBe = 1;
    else if (regWrEn && regWrData[0] && mFull != 0) nBe = 0;
    if (cntEqA && !splitMode && !pcm8Mode) nAm = 1;
    else if (regWrEn && regWrData[1]) nAm = 0;
    if (cntEqB) nBm = 1;
    else if (regWrEn && regWrData[2]) nBm = 0;
    if (softReset) nFull = 0;
    else if (bufWrite) nFull = 1;
    else if (bufLoad) nFull = 0;
    if (softReset) nArmed = 0;
    else if (runEn && mRunQ == 0) nArmed = 1;
    if (regWrEn) begin
      mEnBe = regWrData[4]; mEnAm = regWrData[5]; mEnBm = regWrData[6];
    end
    mBe = nBe; mAm = nAm; mBm = nBm; mFull = nFull; mArmed = nArmed;
    mRunQ = runEn;
  endtask

  task automatic compareAll();
    vecCount++;
    if (regRdData !== expRd() || irqOut !== expIrq() || dmaReq !== expDma()) begin
      failCount++;
      $display("FAIL %s: rd=%h irq=%b dma=%b expected rd=%h irq=%b dma=%b",
               curReq, regRdData, irqOut, dmaReq, expRd(), expIrq(), expDma());
    end
    // R10: reserved bits
    vecCount++;
    if ((regRdData & 8'h88) !== 8'h00) begin
      failCount++;
      $display("FAIL R10: reserved bits %h expected 00", regRdData & 8'h88);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    cntEqA = 0; cntEqB = 0; bufLoad = 0; bufWrite = 0;
    softReset = 0; regWrEn = 0;
  endtask

  task automatic expectBit(input string tag, input logic act, input logic exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [REG_W-1:0] d);
    regWrEn = 1; regWrData = d; tick();
  endtask

  initial begin
    #1_000_000;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    rstN = 0; cntEqA = 0; cntEqB = 0; bufLoad = 0; bufWrite = 0; runEn = 0;
    softReset = 0; splitMode = 0; pcm8Mode = 0; regWrEn = 0; regWrData = '0;
    repeat (3) tick();
    curReq = "R1";
    expectBit("R1 regRd zero", regRdData == 0, 1'b1);
    expectBit("R1 irq", irqOut, 1'b0);
    expectBit("R1 dma", dmaReq, 1'b0);
    rstN = 1;
    tick();

    curReq = "R8";
    writeReg(8'h70);
    expectBit("R8 enables", regRdData == 8'h70, 1'b1);

    curReq = "R7";
    cntEqB = 1; tick();
    expectBit("R7 B flag", regRdData[2], 1'b1);
    expectBit("R8 irq from B", irqOut, 1'b1);

    curReq = "R3";
    writeReg(8'h70);
    expectBit("R3 write 0 keeps B", regRdData[2], 1'b1);
    cntEqB = 1; writeReg(8'h74);
    expectBit("R3 set wins", regRdData[2], 1'b1);
    writeReg(8'h74);
    expectBit("R3 clear B", regRdData[2], 1'b0);

    curReq = "R6";
    cntEqA = 1; tick();
    expectBit("R6 A flag", regRdData[1], 1'b1);
    writeReg(8'h72);
    splitMode = 1; cntEqA = 1; tick(); splitMode = 0;
    expectBit("R6 split blocks", regRdData[1], 1'b0);
    pcm8Mode = 1; cntEqA = 1; tick(); pcm8Mode = 0;
    expectBit("R6 pcm8 blocks", regRdData[1], 1'b0);

    curReq = "R5";
    runEn = 1; tick();
    softReset = 1; tick();
    expectBit("R5 flag set", regRdData[0], 1'b1);
    expectBit("R5 no dma", dmaReq, 1'b0);
    expectBit("R5 no irq", irqOut, 1'b0);
    repeat (3) tick();
    expectBit("R5 still quiet", dmaReq, 1'b0);
    runEn = 0; tick();
    runEn = 1; tick();
    expectBit("R5 dma after run rise", dmaReq, 1'b1);
    expectBit("R5 irq after run rise", irqOut, 1'b1);

    curReq = "R9";
    writeReg(8'h60);
    expectBit("R9 dma without enable", dmaReq, 1'b1);

    curReq = "R4";
    writeReg(8'h61);
    expectBit("R4 clear overridden", regRdData[0], 1'b1);
    bufWrite = 1; tick();
    expectBit("R9 write drops dma", dmaReq, 1'b0);
    writeReg(8'h71);
    expectBit("R4 clear after write", regRdData[0], 1'b0);

    curReq = "R2";
    bufLoad = 1; tick();
    expectBit("R2 load sets flag", regRdData[0], 1'b1);
    expectBit("R9 dma after load", dmaReq, 1'b1);

    curReq = "R1..random";
    for (int n = 0; n < 600; n++) begin
      cntEqA    = ($urandom_range(0, 3) == 0);
      cntEqB    = ($urandom_range(0, 3) == 0);
      bufLoad   = ($urandom_range(0, 5) == 0);
      bufWrite  = ($urandom_range(0, 4) == 0);
      softReset = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 9) == 0) runEn = ~runEn;
      splitMode = ($urandom_range(0, 4) == 0);
      pcm8Mode  = ($urandom_range(0, 4) == 0);
      regWrEn   = ($urandom_range(0, 2) == 0);
      regWrData = REG_W'($urandom);
      if (n == 300) rstN = 0;
      if (n == 303) rstN = 1;
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule